// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block is the receive-side buffer of a full-speed USB device controller's isochronous OUT endpoint. The packet engine hands it bytes one at a time, with strobes that mark the first and last byte of each packet. Accepted packets go into a byte store. A small queue of packet lengths keeps track of where each packet ends while the processor drains the data.

The processor uses a two-address register bus. Address 0 is an 8-bit control/status register. Address 1 is the data port, and each read of it removes one byte. When a packet cannot fit in the free byte space or in the length queue, the whole packet is thrown away, the stored data is left as it was, and a sticky overflow flag records the loss. A completed packet raises an interrupt request, which can be masked by an enable input.

Top module: `iso_rx_buffer`

## Requirements
- R1: Address 0 reads the status byte. Bit 0 is the service flag, bit 1 is packet-done, bit 2 is overflow, bit 6 is not-empty and bit 7 is short-packet. Bits 5:3 always read 0. Address 1 is the data port.
- R2: The service flag reads 1 when at least one stored packet has none of its bytes read yet, and 0 otherwise.
- R3: Packet-done becomes 1 on the cycle after a packet is stored. Writing status with bit 1 set clears it. Writing 0 to bit 1 leaves it unchanged. A new packet stored in the same cycle as a clear wins, and the flag stays set.
- R4: Not-empty reads 1 whenever any unread byte remains in the store.
- R5: A packet is dropped whole when the store lacks room for all of its bytes, or when all length-queue slots are taken. The stored bytes stay unchanged. Overflow (bit 2) is set and stays set until status is written with bit 2 set.
- R6: Short-packet reads 1 when the packet currently at the head has fewer than MAX_PKT (default 256) bytes.
- R7: After reset, every status bit reads 0 and the interrupt request is low.
- R8: Each read of address 1 returns the oldest unread byte and removes it, so bytes come out in arrival order. A read of address 1 while the store is empty returns 0 and changes nothing.
- R9: The store holds PKT_SLOTS (default 2) maximum-size packets, which is 512 bytes by default. The length queue holds up to LENQ_DEPTH (default 4) packets.
- R10: The interrupt request is high exactly while packet-done is set and the interrupt-enable input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe from the packet engine |
| rx_sop | input | 1 | First byte of a packet (qualified by rx_valid) |
| rx_eop | input | 1 | Last byte of a packet (qualified by rx_valid) |
| rx_data | input | 8 | Received byte |
| bus_addr | input | 1 | 0 = status, 1 = data |
| bus_rd | input | 1 | Read strobe (a data read pops one byte) |
| bus_wr | input | 1 | Write strobe (acts on status only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_en | input | 1 | Receive interrupt enable |
| irq | output | 1 | Packet-complete interrupt request |

## Verification
The assertions assume well-formed packets from the engine. Every packet opens with a start strobe, has between one and MAX_PKT bytes, and closes with an end strobe. No byte is presented outside a packet. The bench's driver task builds every packet from a length and a base value, always asserts the start and end strobes on the first and last byte, and never sends more than MAX_PKT bytes. The stimulus therefore never leaves that envelope, even when the test deliberately overfills the store or the length queue.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
   // Status byte layout, most significant bit first.
   typedef struct packed {
      logic       shrt;   // bit 7
      logic       ne;     // bit 6
      logic [2:0] zero;   // bits 5:3
      logic       ovf;    // bit 2
      logic       done;   // bit 1
      logic       svc;    // bit 0
   } iso_rx_stat_t;

   localparam int unsigned BIT_DONE = 1;
   localparam int unsigned BIT_OVF  = 2;
endpackage

// File: rtl/iso_rx_lenq.sv
module iso_rx_lenq #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 9,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full
);
   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;

   initial begin
      assert (DEPTH >= 2) else $error("iso_rx_lenq: DEPTH must be at least 2");
   end

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + PW'(1);
         assign rp_nx = rp + PW'(1);
      end else begin : g_mod
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      end
   endgenerate

   assign full = (count == CW'(DEPTH));
   assign dout = slot[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= din;
   end

   // R9
   lenq_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R9
   lenq_pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
endmodule

// File: rtl/iso_rx_store.sv
module iso_rx_store #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned LEN_W = 9,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [7:0]       in_data,
   input  logic             lenq_full,
   input  logic             pop,
   output logic [7:0]       head_byte,
   output logic [OCC_W-1:0] occ,
   output logic             commit,
   output logic             drop,
   output logic [LEN_W-1:0] commit_len
);
   logic [7:0]       mem [DEPTH];
   logic [AW-1:0]    cptr, sptr, rptr, wptr_here;
   logic [LEN_W-1:0] wcnt, cur_cnt;
   logic             drop_r, cur_drop, room, byte_ok, last;
   logic [31:0]      need;

   initial begin
      assert ((DEPTH & (DEPTH - 1)) == 0)
         else $error("iso_rx_store: DEPTH must be a power of two");
   end

   always_comb begin
      cur_cnt    = in_sop ? '0 : wcnt;
      cur_drop   = in_sop ? 1'b0 : drop_r;
      wptr_here  = in_sop ? cptr : sptr;
      need       = 32'(occ) + 32'(cur_cnt);
      room       = need < 32'(DEPTH);
      byte_ok    = in_valid && !cur_drop && room;
      last       = in_valid && in_eop;
      commit     = last && byte_ok && !lenq_full;
      drop       = last && !commit;
      commit_len = cur_cnt + LEN_W'(1);
   end

   assign head_byte = mem[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cptr   <= '0;
         sptr   <= '0;
         rptr   <= '0;
         occ    <= '0;
         wcnt   <= '0;
         drop_r <= 1'b0;
      end else begin
         if (commit) begin
            cptr <= wptr_here + AW'(1);
            sptr <= wptr_here + AW'(1);
         end else if (drop) begin
            sptr <= cptr;
         end else if (byte_ok) begin
            sptr <= wptr_here + AW'(1);
         end
         if (in_valid) begin
            wcnt   <= byte_ok ? cur_cnt + LEN_W'(1) : cur_cnt;
            drop_r <= cur_drop || !byte_ok;
         end
         if (pop) rptr <= rptr + AW'(1);
         occ <= occ + (commit ? OCC_W'(commit_len) : '0) - (pop ? OCC_W'(1) : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (byte_ok) mem[wptr_here] <= in_data;
   end

   // R9
   occ_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(DEPTH));
   // R5
   drop_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop && !pop |=> $stable(occ));
   // R8
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> occ != '0);
endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
   import iso_rx_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         commit,
   input  logic         drop,
   input  logic         wr_stat,
   input  logic [7:0]   wdata,
   input  logic         svc,
   input  logic         ne,
   input  logic         shrt,
   input  logic         irq_en,
   output iso_rx_stat_t stat,
   output logic         irq
);
   logic done_q, ovf_q;
   logic clr_done, clr_ovf;

   assign clr_done = wr_stat && wdata[BIT_DONE];
   assign clr_ovf  = wr_stat && wdata[BIT_OVF];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (commit)        done_q <= 1'b1;
         else if (clr_done) done_q <= 1'b0;
         if (drop)          ovf_q  <= 1'b1;
         else if (clr_ovf)  ovf_q  <= 1'b0;
      end
   end

   always_comb begin
      stat      = '0;
      stat.svc  = svc;
      stat.done = done_q;
      stat.ovf  = ovf_q;
      stat.ne   = ne;
      stat.shrt = shrt;
   end

   assign irq = done_q && irq_en;

   // R3
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> stat.done);
   // R3
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat && wdata[BIT_DONE] && !commit |=> !stat.done);
   // R5
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> stat.ovf);
   // R5
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat.ovf && !(wr_stat && wdata[BIT_OVF]) |=> stat.ovf);
endmodule

// File: rtl/iso_rx_buffer.sv
module iso_rx_buffer
   import iso_rx_pkg::*;
#(
   parameter int unsigned MAX_PKT    = 256,
   parameter int unsigned PKT_SLOTS  = 2,
   parameter int unsigned LENQ_DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic       rx_sop,
   input  logic       rx_eop,
   input  logic [7:0] rx_data,
   input  logic       bus_addr,
   input  logic       bus_rd,
   input  logic       bus_wr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       irq_en,
   output logic       irq
);
   localparam int unsigned DEPTH = MAX_PKT * PKT_SLOTS;
   localparam int unsigned LEN_W = $clog2(MAX_PKT + 1);
   localparam int unsigned OCC_W = $clog2(DEPTH + 1);
   localparam int unsigned CW    = $clog2(LENQ_DEPTH + 1);

   initial begin
      assert (MAX_PKT >= 2) else $error("iso_rx_buffer: MAX_PKT too small");
      assert (PKT_SLOTS >= 1) else $error("iso_rx_buffer: PKT_SLOTS must be nonzero");
   end

   logic [7:0]       head_byte;
   logic [OCC_W-1:0] occ;
   logic             commit, drop, lenq_full, pop, head_done, head_part;
   logic [LEN_W-1:0] commit_len, head_len, rd_off;
   logic [CW-1:0]    pkt_cnt;
   logic             svc, shrt;
   iso_rx_stat_t     stat;

   assign pop       = bus_rd && bus_addr && (occ != '0);
   assign head_done = pop && ((rd_off + LEN_W'(1)) == head_len);
   assign head_part = (rd_off != '0);
   assign svc       = pkt_cnt > {{(CW-1){1'b0}}, head_part};
   assign shrt      = (pkt_cnt != '0) && (head_len < LEN_W'(MAX_PKT));

   always_ff @(posedge clk) begin
      if (!rst_n)         rd_off <= '0;
      else if (head_done) rd_off <= '0;
      else if (pop)       rd_off <= rd_off + LEN_W'(1);
   end

   iso_rx_store #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rx_valid), .in_sop(rx_sop), .in_eop(rx_eop), .in_data(rx_data),
      .lenq_full(lenq_full), .pop(pop),
      .head_byte(head_byte), .occ(occ),
      .commit(commit), .drop(drop), .commit_len(commit_len)
   );

   iso_rx_lenq #(.DEPTH(LENQ_DEPTH), .W(LEN_W)) u_lenq (
      .clk(clk), .rst_n(rst_n),
      .push(commit), .din(commit_len),
      .pop(head_done), .dout(head_len),
      .count(pkt_cnt), .full(lenq_full)
   );

   iso_rx_csr u_csr (
      .clk(clk), .rst_n(rst_n),
      .commit(commit), .drop(drop),
      .wr_stat(bus_wr && !bus_addr), .wdata(bus_wdata),
      .svc(svc), .ne(occ != '0), .shrt(shrt),
      .irq_en(irq_en), .stat(stat), .irq(irq)
   );

   assign bus_rdata = bus_addr ? ((occ != '0) ? head_byte : 8'h00) : stat;

   // R4
   pkt_implies_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_cnt != '0 |-> occ != '0);
   // R8
   bytes_imply_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ != '0 |-> pkt_cnt != '0);
   // R1
   zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_addr |-> bus_rdata[5:3] == 3'b000);
endmodule

// File: tb/sim_iso_rx_buffer.sv
`timescale 1ns/1ps
module sim_iso_rx_buffer;
   localparam int MAXP = 256;
   localparam int CAP  = 512;
   localparam int LQ   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_en = 1'b0;
   logic       irq;

   always #10 clk = ~clk;

   iso_rx_buffer u0 (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_en(irq_en), .irq(irq)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // Scoreboard state
   byte unsigned exp_bytes[$];
   int           pkt_lens[$];
   int           m_occ = 0, m_off = 0;
   bit           m_done = 1'b0, m_ovf = 1'b0;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_stat();
      int s = 0;
      int whole = pkt_lens.size() - ((m_off != 0) ? 1 : 0);
      if (whole > 0) s |= 1;
      if (m_done) s |= 2;
      if (m_ovf) s |= 4;
      if (m_occ != 0) s |= 8'h40;
      if (pkt_lens.size() > 0 && pkt_lens[0] < MAXP) s |= 8'h80;
      return s;
   endfunction

   // Driver: streams a packet and records what the design should keep.
   task automatic send_pkt(int len, int base);
      bit fits = (m_occ + len <= CAP) && (pkt_lens.size() < LQ);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sop   = (i == 0);
         rx_eop   = (i == len - 1);
         rx_data  = 8'((base + i) & 8'hff);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
      if (fits) begin
         for (int i = 0; i < len; i++) exp_bytes.push_back(8'((base + i) & 8'hff));
         pkt_lens.push_back(len);
         m_occ += len;
         m_done = 1'b1;
      end else begin
         m_ovf = 1'b1;
      end
   endtask

   // Monitor: pops a byte from the design and compares with the scoreboard.
   task automatic rd_data(string req);
      int exp = 0;
      @(negedge clk);
      bus_addr = 1'b1; bus_rd = 1'b1;
      #1;
      if (exp_bytes.size() > 0) exp = exp_bytes.pop_front();
      check(req, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = 1'b0;
      if (m_occ > 0) begin
         m_occ--;
         m_off++;
         if (m_off == pkt_lens[0]) begin
            void'(pkt_lens.pop_front());
            m_off = 0;
         end
      end
   endtask

   task automatic chk_stat(string req);
      @(negedge clk);
      bus_addr = 1'b0;
      #1;
      check(req, bus_rdata, exp_stat());
   endtask

   task automatic wr_stat(logic [7:0] v);
      @(negedge clk);
      bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
      if (v[1]) m_done = 1'b0;
      if (v[2]) m_ovf = 1'b0;
   endtask

   task automatic drain(string req);
      while (m_occ > 0) rd_data(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R7 reset state
      chk_stat("R7");
      check("R7 irq", irq, 0);

      // Short packet: service, done, not-empty, short flags (R2 R3 R4 R6)
      irq_en = 1'b1;
      send_pkt(5, 8'h10);
      chk_stat("R2");
      check("R10 irq enabled", irq, 1);
      irq_en = 1'b0;
      #1 check("R10 irq masked", irq, 0);
      irq_en = 1'b1;

      // R3 write zero no effect, write one clears
      wr_stat(8'h00);
      chk_stat("R3 write0");
      wr_stat(8'h02);
      chk_stat("R3 clear");
      check("R10 irq after clear", irq, 0);

      // R8 read order, R2 service drops once head partially read
      rd_data("R8");
      chk_stat("R2 partial");
      drain("R8");
      chk_stat("R4 empty");
      rd_data("R8 empty read");
      chk_stat("R8 empty no effect");

      // R6 full-size packet not short; R9 two max packets fit
      send_pkt(MAXP, 8'h00);
      chk_stat("R6");
      send_pkt(MAXP, 8'h40);
      chk_stat("R9");
      // R5 no space: dropped whole, contents unchanged
      send_pkt(10, 8'hA0);
      chk_stat("R5 overflow");
      drain("R5 contents");
      chk_stat("R5 after drain");
      wr_stat(8'h04);
      chk_stat("R5 ovf cleared");
      wr_stat(8'h02);

      // R5 length-queue full drop
      for (int k = 0; k < LQ; k++) send_pkt(3, 8'h20 + 8 * k);
      chk_stat("R9 queue full");
      send_pkt(3, 8'hE0);
      chk_stat("R5 queue drop");
      drain("R8 small packets");
      wr_stat(8'h06);
      chk_stat("R1 all clear");

      // R5 partial-room drop mid-packet
      send_pkt(MAXP, 8'h05);
      send_pkt(200, 8'h77);
      send_pkt(100, 8'hC3);
      chk_stat("R5 partial room");
      rd_data("R8");
      chk_stat("R6 head full-size partial");
      drain("R5 kept bytes");
      chk_stat("R4 final");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule